// File: doc/BRIEF.md
# Privileged Special-Register Access Unit

This block serves the move-to and move-from special-register operations of a small microcontroller core. The core presents a register number together with a read or write strobe, write data and a privilege flag. The unit applies the privilege rules, returns the selected register on a registered read port, and updates the state it holds. That state is the condition flags of the status word, a live and a banked stack pointer, the interrupt priority masks and a two-bit control word. The core keeps the lower part of the status word (exception number and execution-state bits) and feeds it in, so the unit can compose the status views.

Register numbers 0 to 7 are views of the status word, and the low bits of the number choose which fields the view shows. Numbers 8 and 9 name the main and the process stack pointer. Each one lives either in the live or in the banked copy, depending on which stack the control word makes active. Unprivileged code may read only the status views and the control word, and may write only the status flags. A privileged access to a number that has no register behind it reads zero, changes nothing and raises a one-cycle error pulse, so the core can report it.

Top module: `spr_access_unit`

## Requirements
- R1: A privileged read of number 0..7 returns bits 31:27 = stored flags when bit 2 of the number is 0, and bits 8:0 = exception number (psr_low[8:0]) when bit 0 of the number is 1. Every other bit reads 0, including the execution-state bits 26:9 that psr_low carries.
- R2: An unprivileged read of number 0..7 returns 0 in bits 8:0 whatever bit 0 of the number is. The flag rule of R1 still applies.
- R3: Number 20 reads as {30'b0, ctrl} at either privilege level.
- R4: An unprivileged read of any number other than 0..7 and 20 returns 0 and raises no error.
- R5: An unprivileged write to any number above 7 changes no state and raises no error.
- R6: A write to number 0..7 with bit 2 clear loads wdata[31:27] into the flags at either privilege level. A view write with bit 2 set changes nothing, and no other status bit is ever written.
- R7: Number 8 reads the main stack pointer: the banked copy when ctrl[1]=1, else the live copy. Number 9 reads the process stack pointer: the live copy when ctrl[1]=1, else the banked copy.
- R8: A privileged write to number 8 or 9 stores wdata into the copy that R7 reads for that number.
- R9: Privileged writes load primask from wdata[0] (number 16), basepri from wdata[7:0] (number 17) and faultmask from wdata[0] (number 19). Reads return these values zero-extended.
- R10: A privileged write to number 20 loads ctrl from wdata[1:0]. When wdata[1] differs from ctrl[1], the live and banked stack pointers exchange values in the same cycle. Otherwise they keep their values.
- R11: A privileged read or write of any number not listed above returns 0 or discards the write, and drives err high for exactly the cycle after the strobe.
- R12: rd_data is registered: it shows the result of the read strobe from the cycle before, and holds its value while rd_en is low. All state resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 8 | Special-register number |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 32 | Write data |
| priv | input | 1 | 1 = privileged access |
| psr_low | input | 27 | Core-held status bits 26:0 (execution state and exception number) |
| rd_data | output | 32 | Registered read result |
| err | output | 1 | One-cycle pulse after a privileged access to an unknown number |
| flags | output | 5 | Stored condition flags (status bits 31:27) |
| sp_live | output | 32 | Stack pointer the core uses now |
| sp_banked | output | 32 | Inactive stack pointer |
| primask | output | 1 | Priority mask bit |
| basepri | output | 8 | Base priority mask |
| faultmask | output | 1 | Fault mask bit |
| ctrl | output | 2 | Control word; bit 1 selects the process stack |

## Verification
An internal fault shows at the ports one cycle after the access that triggers it. A wrong decode of the view bits shows up at once as a bad field in rd_data. A lost or doubled stack swap leaves sp_live and sp_banked exchanged, or left in place, right after the control write. A later read of number 8 or 9 then returns the other pointer. A privilege leak shows as state that moves after an unprivileged write, or as non-zero read data where zero is required. Every check therefore follows each strobe by exactly one cycle.

// File: rtl/spr_pkg.sv
package spr_pkg;

  // Register numbers whose position the core relies on
  localparam int unsigned NUM_VIEW_LAST = 7;
  localparam int unsigned NUM_MSP       = 8;
  localparam int unsigned NUM_PSP       = 9;
  localparam int unsigned NUM_PMASK     = 16;
  localparam int unsigned NUM_PRIO      = 17;
  localparam int unsigned NUM_FMASK     = 19;
  localparam int unsigned NUM_CTRL      = 20;

  localparam int unsigned CTRL_W     = 2;
  localparam int unsigned CTRL_SPSEL = 1;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_VIEW,
    TGT_MSP,
    TGT_PSP,
    TGT_PMASK,
    TGT_PRIO,
    TGT_FMASK,
    TGT_CTRL
  } spr_tgt_e;

endpackage

// File: rtl/spr_decode.sv
module spr_decode
  import spr_pkg::*;
#(
  parameter int unsigned SEL_W = 8
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             priv,
  input  logic             rd_en,
  input  logic             wr_en,
  output spr_tgt_e         tgt,
  output logic             rd_ok,
  output logic             wr_ok,
  output logic             bad_acc
);

  logic known;
  logic open_to_user_rd;

  always_comb begin
    if (sel <= SEL_W'(NUM_VIEW_LAST))  tgt = TGT_VIEW;
    else if (sel == SEL_W'(NUM_MSP))   tgt = TGT_MSP;
    else if (sel == SEL_W'(NUM_PSP))   tgt = TGT_PSP;
    else if (sel == SEL_W'(NUM_PMASK)) tgt = TGT_PMASK;
    else if (sel == SEL_W'(NUM_PRIO))  tgt = TGT_PRIO;
    else if (sel == SEL_W'(NUM_FMASK)) tgt = TGT_FMASK;
    else if (sel == SEL_W'(NUM_CTRL))  tgt = TGT_CTRL;
    else                               tgt = TGT_NONE;
  end

  assign known           = (tgt != TGT_NONE);
  assign open_to_user_rd = (tgt == TGT_VIEW) || (tgt == TGT_CTRL);

  assign rd_ok   = rd_en && (priv ? known : open_to_user_rd);
  assign wr_ok   = wr_en && known && (priv || (tgt == TGT_VIEW));
  assign bad_acc = priv && (rd_en || wr_en) && !known;

endmodule

// File: rtl/spr_psr_view.sv
module spr_psr_view #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EXC_W  = 9,
  parameter int unsigned FLG_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_exc,
  input  logic                    sel_noflg,
  input  logic                    priv,
  input  logic                    wr,
  input  logic [FLG_W-1:0]        wflags,
  input  logic [DATA_W-FLG_W-1:0] psr_low,
  output logic [FLG_W-1:0]        flags_q,
  output logic [DATA_W-1:0]       view_word
);

  // Field mask of one status view, from the number's bits and privilege
  function automatic logic [DATA_W-1:0] view_mask(input logic exc_bit,
                                                  input logic noflg_bit,
                                                  input logic p);
    logic [DATA_W-1:0] m;
    m = '0;
    if (exc_bit && p) m[EXC_W-1:0] = '1;
    if (!noflg_bit)   m[DATA_W-1 -: FLG_W] = '1;
    return m;
  endfunction

  logic flag_load;
  assign flag_load = wr && !sel_noflg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flags_q <= '0;
    else if (flag_load) flags_q <= wflags;
  end

  assign view_word = {flags_q, psr_low} & view_mask(sel_exc, sel_noflg, priv);

  // R6: a view write with bit 2 of the number set leaves the flags alone
  p_flags_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel_noflg) |=> $stable(flags_q));

  // R6: a view write with bit 2 clear loads the flags
  p_flags_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !sel_noflg) |=> (flags_q == $past(wflags)));

endmodule

// File: rtl/spr_stack_bank.sv
module spr_stack_bank #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psp_act,
  input  logic              wr_msp,
  input  logic              wr_psp,
  input  logic              swap,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] live_q,
  output logic [DATA_W-1:0] bank_q,
  output logic [DATA_W-1:0] msp_rd,
  output logic [DATA_W-1:0] psp_rd
);

  logic live_wr;
  logic bank_wr;

  // The main pointer is live unless the process stack is active
  assign live_wr = (wr_msp && !psp_act) || (wr_psp && psp_act);
  assign bank_wr = (wr_msp && psp_act)  || (wr_psp && !psp_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      bank_q <= '0;
    end else if (swap) begin
      live_q <= bank_q;
      bank_q <= live_q;
    end else begin
      if (live_wr) live_q <= wdata;
      if (bank_wr) bank_q <= wdata;
    end
  end

  assign msp_rd = psp_act ? bank_q : live_q;
  assign psp_rd = psp_act ? live_q : bank_q;

  // R10: a stack switch exchanges the two copies
  p_swap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (live_q == $past(bank_q)) && (bank_q == $past(live_q)));

  // R8: a main-pointer write with the main stack active hits the live copy
  p_msp_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_msp && !psp_act) |=> (live_q == $past(wdata)) && $stable(bank_q));

  // R8: a process-pointer write with the main stack active hits the banked copy
  p_psp_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_psp && !psp_act) |=> (bank_q == $past(wdata)) && $stable(live_q));

endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
  import spr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 8,
  parameter int unsigned EXC_W  = 9,
  parameter int unsigned FLG_W  = 5,
  parameter int unsigned PRIO_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SEL_W-1:0]        sel,
  input  logic                    rd_en,
  input  logic                    wr_en,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    priv,
  input  logic [DATA_W-FLG_W-1:0] psr_low,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    err,
  output logic [FLG_W-1:0]        flags,
  output logic [DATA_W-1:0]       sp_live,
  output logic [DATA_W-1:0]       sp_banked,
  output logic                    primask,
  output logic [PRIO_W-1:0]       basepri,
  output logic                    faultmask,
  output logic [CTRL_W-1:0]       ctrl
);

  localparam int unsigned LOW_W = DATA_W - FLG_W;

  // Decode events, named for the assertions
  spr_tgt_e tgt;
  logic     rd_ok;
  logic     wr_ok;
  logic     bad_acc;

  spr_decode #(.SEL_W(SEL_W)) u_dec (
    .sel     (sel),
    .priv    (priv),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .tgt     (tgt),
    .rd_ok   (rd_ok),
    .wr_ok   (wr_ok),
    .bad_acc (bad_acc)
  );

  logic wr_view;
  logic wr_msp;
  logic wr_psp;
  logic wr_pmask;
  logic wr_prio;
  logic wr_fmask;
  logic wr_ctrl;
  logic sp_swap;

  assign wr_view  = wr_ok && (tgt == TGT_VIEW);
  assign wr_msp   = wr_ok && (tgt == TGT_MSP);
  assign wr_psp   = wr_ok && (tgt == TGT_PSP);
  assign wr_pmask = wr_ok && (tgt == TGT_PMASK);
  assign wr_prio  = wr_ok && (tgt == TGT_PRIO);
  assign wr_fmask = wr_ok && (tgt == TGT_FMASK);
  assign wr_ctrl  = wr_ok && (tgt == TGT_CTRL);

  logic [CTRL_W-1:0] ctrl_q;
  assign sp_swap = wr_ctrl && (wdata[CTRL_SPSEL] != ctrl_q[CTRL_SPSEL]);

  // Status views
  logic [DATA_W-1:0] view_word;

  spr_psr_view #(
    .DATA_W (DATA_W),
    .EXC_W  (EXC_W),
    .FLG_W  (FLG_W)
  ) u_view (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_exc   (sel[0]),
    .sel_noflg (sel[2]),
    .priv      (priv),
    .wr        (wr_view),
    .wflags    (wdata[DATA_W-1 -: FLG_W]),
    .psr_low   (psr_low),
    .flags_q   (flags),
    .view_word (view_word)
  );

  // Stack pointers
  logic [DATA_W-1:0] msp_rd;
  logic [DATA_W-1:0] psp_rd;

  spr_stack_bank #(.DATA_W(DATA_W)) u_sp (
    .clk     (clk),
    .rst_n   (rst_n),
    .psp_act (ctrl_q[CTRL_SPSEL]),
    .wr_msp  (wr_msp),
    .wr_psp  (wr_psp),
    .swap    (sp_swap),
    .wdata   (wdata),
    .live_q  (sp_live),
    .bank_q  (sp_banked),
    .msp_rd  (msp_rd),
    .psp_rd  (psp_rd)
  );

  // Masks and control word
  logic              pmask_q;
  logic [PRIO_W-1:0] prio_q;
  logic              fmask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmask_q <= 1'b0;
      prio_q  <= '0;
      fmask_q <= 1'b0;
      ctrl_q  <= '0;
    end else begin
      if (wr_pmask) pmask_q <= wdata[0];
      if (wr_prio)  prio_q  <= wdata[PRIO_W-1:0];
      if (wr_fmask) fmask_q <= wdata[0];
      if (wr_ctrl)  ctrl_q  <= wdata[CTRL_W-1:0];
    end
  end

  // Read selection
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    unique case (tgt)
      TGT_VIEW:  rd_mux = view_word;
      TGT_MSP:   rd_mux = msp_rd;
      TGT_PSP:   rd_mux = psp_rd;
      TGT_PMASK: rd_mux = DATA_W'(pmask_q);
      TGT_PRIO:  rd_mux = DATA_W'(prio_q);
      TGT_FMASK: rd_mux = DATA_W'(fmask_q);
      TGT_CTRL:  rd_mux = DATA_W'(ctrl_q);
      default:   rd_mux = '0;
    endcase
  end

  logic [DATA_W-1:0] rd_q;
  logic              err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (rd_en) rd_q <= rd_ok ? rd_mux : '0;
      err_q <= bad_acc;
    end
  end

  assign rd_data   = rd_q;
  assign err       = err_q;
  assign primask   = pmask_q;
  assign basepri   = prio_q;
  assign faultmask = fmask_q;
  assign ctrl      = ctrl_q;

  // R1: execution-state bits never show through a status view
  p_exec_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (sel <= SEL_W'(NUM_VIEW_LAST))) |=> (rd_data[LOW_W-1:EXC_W] == '0));

  // R2: the exception number stays hidden from unprivileged reads
  p_exc_hidden_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !priv && (sel <= SEL_W'(NUM_VIEW_LAST))) |=> (rd_data[EXC_W-1:0] == '0));

  // R4: unprivileged reads outside the views and control word give zero, no error
  p_user_rd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !priv && (sel > SEL_W'(NUM_VIEW_LAST)) && (sel != SEL_W'(NUM_CTRL)))
      |=> (rd_data == '0) && !err);

  // R5: unprivileged writes above 7 leave every state field alone
  p_user_wr_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !priv && (sel > SEL_W'(NUM_VIEW_LAST)))
      |=> $stable({sp_live, sp_banked, primask, basepri, faultmask, ctrl}));

  // R11: no strobe, no error in the next cycle
  p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |=> !err);

  // R12: read data holds while no read is strobed
  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/spr_access_unit_tb.sv
`timescale 1ns/1ps
module spr_access_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic [7:0]  sel;
  logic        rd_en;
  logic        wr_en;
  logic [31:0] wdata;
  logic        priv;
  logic [26:0] psr_low;
  logic [31:0] rd_data;
  logic        err;
  logic [4:0]  flags;
  logic [31:0] sp_live;
  logic [31:0] sp_banked;
  logic        primask;
  logic [7:0]  basepri;
  logic        faultmask;
  logic [1:0]  ctrl;

  spr_access_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .priv      (priv),
    .psr_low   (psr_low),
    .rd_data   (rd_data),
    .err       (err),
    .flags     (flags),
    .sp_live   (sp_live),
    .sp_banked (sp_banked),
    .primask   (primask),
    .basepri   (basepri),
    .faultmask (faultmask),
    .ctrl      (ctrl)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    bit          is_rd;
    logic [31:0] data;
    bit          err;
    string       req;
  } item_t;
  item_t exp_q[$];

  // Reference state, kept from the requirements
  logic [4:0]  m_flags = '0;
  logic [31:0] m_live  = '0;
  logic [31:0] m_bank  = '0;
  logic        m_pm    = 1'b0;
  logic [7:0]  m_bp    = '0;
  logic        m_fm    = 1'b0;
  logic [1:0]  m_ctrl  = '0;
  logic [31:0] last_rd = '0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic bit is_known(input logic [7:0] s);
    return (s <= 8'd9) || (s == 8'd16) || (s == 8'd17) || (s == 8'd19) || (s == 8'd20);
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] s, input bit p);
    logic [31:0] w;
    w = '0;
    if (s <= 8'd7) begin
      if (s[0] && p) w[8:0] = psr_low[8:0];
      if (!s[2])     w[31:27] = m_flags;
      return w;
    end
    if (s == 8'd20) return {30'b0, m_ctrl};
    if (!p) return '0;
    case (s)
      8'd8:    w = m_ctrl[1] ? m_bank : m_live;
      8'd9:    w = m_ctrl[1] ? m_live : m_bank;
      8'd16:   w = {31'b0, m_pm};
      8'd17:   w = {24'b0, m_bp};
      8'd19:   w = {31'b0, m_fm};
      default: w = '0;
    endcase
    return w;
  endfunction

  task automatic model_write(input logic [7:0] s, input logic [31:0] d, input bit p);
    logic [31:0] t;
    if (s <= 8'd7) begin
      if (!s[2]) m_flags = d[31:27];
    end else if (p) begin
      case (s)
        8'd8:  if (m_ctrl[1]) m_bank = d; else m_live = d;
        8'd9:  if (m_ctrl[1]) m_live = d; else m_bank = d;
        8'd16: m_pm = d[0];
        8'd17: m_bp = d[7:0];
        8'd19: m_fm = d[0];
        8'd20: begin
          if (d[1] != m_ctrl[1]) begin
            t = m_live; m_live = m_bank; m_bank = t;
          end
          m_ctrl = d[1:0];
        end
        default: ;
      endcase
    end
  endtask

  // Driver: one strobe per call, expected result pushed to the scoreboard
  task automatic acc(input bit wr, input logic [7:0] s, input logic [31:0] d,
                     input bit p, input string req);
    item_t it;
    @(negedge clk);
    sel   = s;
    wdata = d;
    priv  = p;
    rd_en = !wr;
    wr_en = wr;
    it.is_rd = !wr;
    it.data  = wr ? 32'h0 : model_read(s, p);
    it.err   = p && !is_known(s);
    it.req   = req;
    exp_q.push_back(it);
    if (wr) model_write(s, d, p);
    else    last_rd = it.data;
  endtask

  task automatic idle();
    @(negedge clk);
    rd_en = 1'b0;
    wr_en = 1'b0;
  endtask

  task automatic chk_state(input string req);
    check(req, "flags",     {27'b0, flags},     {27'b0, m_flags});
    check(req, "sp_live",   sp_live,            m_live);
    check(req, "sp_banked", sp_banked,          m_bank);
    check(req, "primask",   {31'b0, primask},   {31'b0, m_pm});
    check(req, "basepri",   {24'b0, basepri},   {24'b0, m_bp});
    check(req, "faultmask", {31'b0, faultmask}, {31'b0, m_fm});
    check(req, "ctrl",      {30'b0, ctrl},      {30'b0, m_ctrl});
  endtask

  // Monitor: compares each strobe's result one cycle later
  initial begin
    bit st;
    item_t it;
    wait (rst_n === 1'b1);
    forever begin
      @(posedge clk);
      st = rd_en || wr_en;
      @(negedge clk);
      if (st) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R12 scoreboard empty act=1 exp=0");
        end else begin
          it = exp_q.pop_front();
          if (it.is_rd) check(it.req, "rd_data", rd_data, it.data);
          check(it.req, "err", {31'b0, err}, {31'b0, it.err});
        end
      end else begin
        check("R11", "err idle", {31'b0, err}, 32'h0);
      end
    end
  end

  initial begin
    rst_n = 1'b0; sel = '0; rd_en = 1'b0; wr_en = 1'b0;
    wdata = '0; priv = 1'b0; psr_low = 27'h7FFFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R12: reset values
    check("R12", "rd_data reset", rd_data, 32'h0);
    chk_state("R12");

    // R6: flags through view 0 (privileged) and view 2 (unprivileged)
    acc(1, 8'd0, 32'hA800_0000, 1, "R6"); idle(); chk_state("R6");
    acc(1, 8'd4, 32'hF800_0000, 1, "R6"); idle(); chk_state("R6");
    acc(1, 8'd6, 32'h5000_0000, 0, "R6"); idle(); chk_state("R6");
    acc(1, 8'd2, 32'h7FFF_FFFF, 0, "R6"); idle(); chk_state("R6");

    // R1 / R2: all views, both privilege levels, two core status patterns
    for (int v = 0; v < 8; v++) acc(0, 8'(v), 32'h0, 1, "R1");
    for (int v = 0; v < 8; v++) acc(0, 8'(v), 32'h0, 0, "R2");
    idle();
    psr_low = 27'h0123_0A7;
    for (int v = 0; v < 8; v++) acc(0, 8'(v), 32'h0, 1, "R1");
    idle();

    // R8 / R7: stack pointers on the main stack
    acc(1, 8'd8, 32'h2000_1000, 1, "R8");
    acc(1, 8'd9, 32'h2000_0800, 1, "R8"); idle(); chk_state("R8");
    acc(0, 8'd8, 32'h0, 1, "R7");
    acc(0, 8'd9, 32'h0, 1, "R7"); idle();

    // R10: switch to the process stack, then write without a switch
    acc(1, 8'd20, 32'h0000_0002, 1, "R10"); idle(); chk_state("R10");
    acc(0, 8'd8, 32'h0, 1, "R7");
    acc(0, 8'd9, 32'h0, 1, "R7");
    acc(1, 8'd8, 32'h1FFF_F000, 1, "R8");
    acc(1, 8'd9, 32'h1FFF_E000, 1, "R8"); idle(); chk_state("R8");
    acc(1, 8'd20, 32'hFFFF_FFFB, 1, "R10"); idle(); chk_state("R10");

    // R3: control readable unprivileged; R4: other reads zero
    acc(0, 8'd20, 32'h0, 0, "R3");
    acc(0, 8'd20, 32'h0, 1, "R3");
    acc(0, 8'd8,  32'h0, 0, "R4");
    acc(0, 8'd9,  32'h0, 0, "R4");
    acc(0, 8'd10, 32'h0, 0, "R4"); idle();

    // R9: masks
    acc(1, 8'd16, 32'hFFFF_FFFF, 1, "R9");
    acc(1, 8'd17, 32'h1234_56C3, 1, "R9");
    acc(1, 8'd19, 32'h0000_0003, 1, "R9"); idle(); chk_state("R9");
    acc(0, 8'd16, 32'h0, 1, "R9");
    acc(0, 8'd17, 32'h0, 1, "R9");
    acc(0, 8'd19, 32'h0, 1, "R9");
    acc(0, 8'd16, 32'h0, 0, "R4"); idle();

    // R5: unprivileged writes above 7 ignored
    acc(1, 8'd8,  32'hDEAD_BEEF, 0, "R5");
    acc(1, 8'd9,  32'hCAFE_F00D, 0, "R5");
    acc(1, 8'd16, 32'h0, 0, "R5");
    acc(1, 8'd17, 32'h0, 0, "R5");
    acc(1, 8'd19, 32'h0, 0, "R5");
    acc(1, 8'd20, 32'h0, 0, "R5"); idle(); chk_state("R5");

    // R11: privileged unknown numbers
    acc(0, 8'd10,  32'h0, 1, "R11");
    acc(0, 8'd18,  32'h0, 1, "R11");
    acc(0, 8'd255, 32'h0, 1, "R11");
    acc(1, 8'd21,  32'hFFFF_FFFF, 1, "R11"); idle(); chk_state("R11");

    // R10: swap back to the main stack
    acc(1, 8'd20, 32'h0, 1, "R10"); idle(); chk_state("R10");
    acc(0, 8'd8, 32'h0, 1, "R7");

    // R12: read data holds across idle cycles
    acc(0, 8'd17, 32'h0, 1, "R12");
    idle();
    repeat (3) @(negedge clk);
    check("R12", "rd_data hold", rd_data, last_rd);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL R12 watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule